// File: doc/BRIEF.md
# Virtual Channel with Main and Bypass Queues

This block models one virtual channel at a link port. Packet descriptors are stored in one of two queues: a main queue or a bypass queue. Each queue has its own credit counter, fed by credit-return pulses from the link partner. Packets that are marked bypassable can overtake a main-queue head that is stalled for lack of credit. This lets posted writes move past a stalled read, which keeps the link free of deadlock.

The steering rule is simple. A plain packet always joins the main queue. A bypassable packet joins the main queue when that queue is empty or its head holds credit. When the main queue is occupied and its credit is zero, the bypassable packet joins the bypass queue instead.

On every cycle the output stage sends at most one descriptor. The bypass head goes first whenever bypass credit is available. The main head goes when its credit is available. A send spends one credit from the queue it came from.

Top module: `vc_bypass_channel`

## Requirements
- R1: After reset both queues are empty and both credit counters are zero, so `out_valid` is low and `in_ready` is high for either value of `in_bypassable`.
- R2: A packet with `in_bypassable`=0 always enters the main queue. For such a packet, `in_ready` is high exactly when the main queue holds fewer than MAIN_DEPTH entries.
- R3: A packet with `in_bypassable`=1 enters the main queue when the main queue is empty or main credit is nonzero. Otherwise it enters the bypass queue. `in_ready` is high exactly when the chosen queue is not full (BYP_DEPTH for the bypass queue).
- R4: In any cycle where the bypass queue is non-empty and bypass credit is nonzero, the bypass head is sent with `out_src`=1. Otherwise, if the main queue is non-empty and main credit is nonzero, the main head is sent with `out_src`=0. Otherwise `out_valid` is 0. A descriptor shown with `out_valid` high leaves its queue at that clock edge.
- R5: Each credit-return pulse adds one to the credit of its own queue. Each send subtracts one from the credit of the queue it came from. A return and a send in the same cycle leave the count unchanged. The counters are CRED_W bits wide, and the partner never returns credit beyond 2**CRED_W-1.
- R6: Each queue delivers its descriptors in the order it accepted them.
- R7: While the main head is stalled at zero main credit, bypassable packets that arrive behind it are sent as soon as bypass credit is returned, and the main head stays queued.
- R8: A queue can accept a packet and send its head in the same cycle. The acceptance is governed only by the fullness the queue had at the start of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor offered on `in_data` |
| in_ready | output | 1 | The queue chosen for the offered descriptor has room |
| in_bypassable | input | 1 | Descriptor may overtake a stalled main head |
| in_data | input | DATA_W | Packet descriptor |
| main_credit_ret | input | 1 | One credit returned for the main queue |
| byp_credit_ret | input | 1 | One credit returned for the bypass queue |
| out_valid | output | 1 | A descriptor is sent this cycle |
| out_src | output | 1 | 1 when the sent descriptor comes from the bypass queue |
| out_data | output | DATA_W | Sent descriptor |

## Verification
If a queue pointer or count is corrupted, it shows up in the same cycle as a wrong `in_ready` level. It shows up again at the next send from that queue as a descriptor out of order. If a credit count is corrupted, it shows up as a send that should not happen, or a send that is missing, in the first cycle where that queue has a head waiting. The sweep runs over a small configuration, with credit-return rates that vary between phases. This keeps the main head stalled often, so the steering choice and the bypass-first choice are both exercised against a queue model kept in the bench.

// File: rtl/vcb_pkg.sv
package vcb_pkg;
    typedef enum logic {
        SRC_MAIN = 1'b0,
        SRC_BYP  = 1'b1
    } vcb_src_e;

    localparam int NUM_Q  = 2;
    localparam int Q_MAIN = 0;
    localparam int Q_BYP  = 1;
endpackage

// File: rtl/vcb_fifo.sv
module vcb_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wr;
        logic [AW-1:0]           rd;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wr] = push_data;
            st_d.wr = (st_q.wr == AW'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        end
        if (pop) begin
            st_d.rd = (st_q.rd == AW'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        end
        st_d.cnt = st_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head  = st_q.mem[st_q.rd];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));

    // R2 R3: the steering logic never writes into a full queue
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop));
    // R4: the scheduler never takes from an empty queue
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/vcb_credit.sv
module vcb_credit #(
    parameter int CW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ret,
    input  logic take,
    output logic nonzero
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } cred_st_t;

    cred_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + CW'(ret) - CW'(take);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign nonzero = (st_q.cnt != '0);

    // R5: a send is only taken against a held credit
    a_r5_take_needs_credit: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (st_q.cnt != '0));
    // R5: a net return never wraps the counter
    a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && !take) |-> (st_q.cnt != '1));
endmodule

// File: rtl/vc_bypass_channel.sv
module vc_bypass_channel
    import vcb_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int MAIN_DEPTH = 8,
    parameter int BYP_DEPTH  = 4,
    parameter int CRED_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_bypassable,
    input  logic [DATA_W-1:0] in_data,
    input  logic              main_credit_ret,
    input  logic              byp_credit_ret,
    output logic              out_valid,
    output logic              out_src,
    output logic [DATA_W-1:0] out_data
);
    logic [DATA_W-1:0] q_head [NUM_Q];
    logic [NUM_Q-1:0]  q_empty, q_full, q_push, q_pop, q_cred, q_ret;

    logic main_stalled, to_byp, send_byp, send_main;

    assign q_ret[Q_MAIN] = main_credit_ret;
    assign q_ret[Q_BYP]  = byp_credit_ret;

    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        localparam int D = (q == Q_MAIN) ? MAIN_DEPTH : BYP_DEPTH;

        vcb_fifo #(.W(DATA_W), .DEPTH(D)) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (q_push[q]),
            .push_data (in_data),
            .pop       (q_pop[q]),
            .head      (q_head[q]),
            .empty     (q_empty[q]),
            .full      (q_full[q])
        );

        vcb_credit #(.CW(CRED_W)) u_cred (
            .clk     (clk),
            .rst_n   (rst_n),
            .ret     (q_ret[q]),
            .take    (q_pop[q]),
            .nonzero (q_cred[q])
        );
    end

    always_comb begin
        // steering
        main_stalled = !q_empty[Q_MAIN] && !q_cred[Q_MAIN];
        to_byp       = in_bypassable && main_stalled;
        in_ready     = to_byp ? !q_full[Q_BYP] : !q_full[Q_MAIN];
        q_push         = '0;
        q_push[Q_BYP]  = in_valid && in_ready && to_byp;
        q_push[Q_MAIN] = in_valid && in_ready && !to_byp;

        // output choice: bypass first
        send_byp  = !q_empty[Q_BYP] && q_cred[Q_BYP];
        send_main = !send_byp && !q_empty[Q_MAIN] && q_cred[Q_MAIN];
        q_pop         = '0;
        q_pop[Q_BYP]  = send_byp;
        q_pop[Q_MAIN] = send_main;

        out_valid = send_byp || send_main;
        out_src   = send_byp ? SRC_BYP : SRC_MAIN;
        out_data  = send_byp ? q_head[Q_BYP] : q_head[Q_MAIN];
    end

    // R2: a plain packet lands in the main queue
    a_r2_plain_to_main: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_bypassable) |=> !q_empty[Q_MAIN]);
    // R3: a bypassable packet behind a stalled main head lands in the bypass queue
    a_r3_steer_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_bypassable && !q_empty[Q_MAIN] && !q_cred[Q_MAIN])
        |=> !q_empty[Q_BYP]);
    // R4: nothing is sent while both queues are empty
    a_r4_idle_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (q_empty == '1) |-> !out_valid);
    // R7: a main send never happens while the bypass queue is both ready and credited
    a_r7_bypass_first: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_src == SRC_MAIN) |-> (q_empty[Q_BYP] || !q_cred[Q_BYP]));
endmodule

// File: tb/tb_vc_bypass_channel.sv
`timescale 1ns/1ps
module tb_vc_bypass_channel;
    localparam int DW   = 8;
    localparam int MD   = 4;
    localparam int BD   = 3;
    localparam int CW   = 4;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_bypassable = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          main_credit_ret = 1'b0;
    logic          byp_credit_ret = 1'b0;
    logic          in_ready, out_valid, out_src;
    logic [DW-1:0] out_data;

    always #4 clk = ~clk;

    vc_bypass_channel #(.DATA_W(DW), .MAIN_DEPTH(MD), .BYP_DEPTH(BD), .CRED_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_bypassable(in_bypassable), .in_data(in_data),
        .main_credit_ret(main_credit_ret), .byp_credit_ret(byp_credit_ret),
        .out_valid(out_valid), .out_src(out_src), .out_data(out_data)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [DW-1:0] mq[$];
    logic [DW-1:0] bq[$];
    int mc = 0;
    int bc = 0;
    int main_sent = 0;
    int byp_sent = 0;

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one cycle: drive after the falling edge, compare, then advance the model
    task automatic step(bit iv, bit ib, logic [DW-1:0] d, bit mr, bit br);
        bit stalled, tb, rdy, sb, sm, acc;
        if (mr && mc >= CMAX) mr = 1'b0;
        if (br && bc >= CMAX) br = 1'b0;
        @(negedge clk);
        in_valid = iv; in_bypassable = ib; in_data = d;
        main_credit_ret = mr; byp_credit_ret = br;
        #1;
        stalled = (mq.size() != 0) && (mc == 0);
        tb  = ib && stalled;
        rdy = tb ? (bq.size() < BD) : (mq.size() < MD);
        sb  = (bq.size() > 0) && (bc > 0);
        sm  = !sb && (mq.size() > 0) && (mc > 0);
        if ((tb && sb) || (!tb && sm))
            check("R8 in_ready with same-queue send", int'(in_ready), int'(rdy));
        else if (ib)
            check("R3 in_ready bypassable", int'(in_ready), int'(rdy));
        else
            check("R2 in_ready plain", int'(in_ready), int'(rdy));
        check("R4 R5 out_valid", int'(out_valid), int'(sb || sm));
        if (sb || sm) begin
            check("R4 out_src", int'(out_src), int'(sb));
            check("R6 out_data order", int'(out_data), int'(sb ? bq[0] : mq[0]));
        end
        acc = iv && rdy;
        if (sb) begin void'(bq.pop_front()); byp_sent++; end
        if (sm) begin void'(mq.pop_front()); main_sent++; end
        if (acc) begin
            if (tb) bq.push_back(d);
            else    mq.push_back(d);
        end
        mc = mc + int'(mr) - int'(sm);
        bc = bc + int'(br) - int'(sb);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 out_valid after reset", int'(out_valid), 0);
        check("R1 in_ready plain after reset", int'(in_ready), 1);
        in_bypassable = 1'b1;
        #1;
        check("R1 in_ready bypassable after reset", int'(in_ready), 1);

        // R2: fill the main queue with no credit, then one more is refused
        for (int i = 0; i < MD + 1; i++) step(1'b1, 1'b0, DW'(8'h10 + i), 1'b0, 1'b0);
        check("R2 main queue holds depth", mq.size(), MD);

        // R3 R7: bypassable packets go around the stalled head
        step(1'b1, 1'b1, 8'hA0, 1'b0, 1'b0);
        step(1'b1, 1'b1, 8'hA1, 1'b0, 1'b0);
        check("R3 bypass queue filled", bq.size(), 2);
        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
        check("R7 bypass sent past stalled head", byp_sent, 2);
        check("R7 main head still held", main_sent, 0);

        // R5 R6: main credits release the main queue in order
        for (int i = 0; i < MD; i++) step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
        check("R5 one send per main credit", main_sent, MD);

        // R3: bypassable into an empty main queue stays in the main queue
        step(1'b1, 1'b1, 8'hC5, 1'b0, 1'b0);
        check("R3 bypassable to empty main", mq.size(), 1);
        step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0);

        // sweep: varying offered load, bypass mix and credit rates
        for (int ph = 0; ph < 8; ph++) begin
            for (int c = 0; c < 1500; c++) begin
                int pin, pbyp, pm, pb;
                pin  = 30 + 10 * (ph % 4);
                pbyp = (ph < 4) ? 50 : 80;
                pm   = (ph % 2 == 0) ? 10 : 40;
                pb   = (ph % 3 == 0) ? 15 : 45;
                step($urandom_range(0, 99) < pin, $urandom_range(0, 99) < pbyp,
                     DW'($urandom), $urandom_range(0, 99) < pm,
                     $urandom_range(0, 99) < pb);
            end
        end

        // drain so every accepted descriptor is seen
        for (int i = 0; i < 40; i++) step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
        check("R6 all descriptors delivered", mq.size() + bq.size(), 0);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule